// File: doc/BRIEF.md
# Shift-and-Add Result Combiner

This block is the result stage that sits behind an array of eight multiply-accumulate cells. A 3-bit address picks one of the eight 26-bit cell accumulators. In select mode the stage shows that value on its result bus. In shift-add mode it adds that value to its own 26-bit accumulator, after the accumulator has first been shifted right by 8 bits. Stepping the address through the cells, from the least significant partial sum to the most significant, builds a result wider than one 8-bit-by-8-bit product.

The address and the mode control are registered before use. A new result is captured only on the first clock of each new selection. While the address stays the same, the result is frozen, so a slow reader can hold a value for several cycles. The 26-bit result leaves the block as a lower half of 16 bits and an upper half of 10 bits. Each half has its own active-low enable. A disabled half reads as zero and its valid flag is low.

Top module: `shadd_combiner`

## Requirements
- R1: While `rst_n` is low, and after it is released, the internal result and accumulator are zero until the first capture.
- R2: In select mode (`shadd_i`=0), an address applied before clock edge k is captured at edge k+1. The result is then `cell_acc_i[addr*26 +: 26]`, taken from the value present at edge k+1.
- R3: In shift-add mode (`shadd_i`=1), a capture sets accumulator and result to `selected + (accumulator >> 8)`, truncated to 26 bits. In select mode the accumulator is left unchanged.
- R4: When `signed_i`=1 the right shift is arithmetic and copies bit 25 into the top 8 bits. When `signed_i`=0 the shift is logical and fills with zeros.
- R5: While the registered address equals its previous value, the result keeps its captured value and ignores changes to the addressed cell accumulator.
- R6: Every change of the registered address, and the first valid address after reset or clear, triggers a new capture.
- R7: `out_lo_o` carries result bits 15:0 when `en_lo_n`=0, and `out_hi_o` carries bits 25:16 when `en_hi_n`=0. The enables act combinationally, either or both may be low, and a disabled half reads as zero with its valid flag low.
- R8: `clr_n` low, sampled at edge k, clears the result, the accumulator and the selection history at edge k+1. No capture happens at that edge.
- R9: `shadd_i` is registered together with the address, so the mode applied with an address governs that address's capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_n | input | 1 | Synchronous active-low clear of the stage, registered one clock |
| cell_acc_i | input | 208 | Eight packed 26-bit cell accumulators; cell n at bits n*26 +: 26 |
| addr_i | input | 3 | Cell select |
| shadd_i | input | 1 | 1 = shift-add mode, 0 = select mode |
| signed_i | input | 1 | 1 = two's complement data (arithmetic shift) |
| en_lo_n | input | 1 | Active-low enable of result bits 15:0 |
| en_hi_n | input | 1 | Active-low enable of result bits 25:16 |
| out_lo_o | output | 16 | Result bits 15:0, zero when disabled |
| out_lo_vld_o | output | 1 | Lower half driven |
| out_hi_o | output | 10 | Result bits 25:16, zero when disabled |
| out_hi_vld_o | output | 1 | Upper half driven |

## Verification
An address and mode applied before edge k produce a result at edge k+1, two registers down the line. A clear sampled at edge k takes effect at edge k+1. The enables act on the result halves within the same cycle. The bench's reference model advances at each rising edge, on the same input values the design sees. The outputs are compared 1 ns after every rising edge, so each expected value already includes both register stages, and enable changes made at the falling edge have settled.

// File: rtl/shadd_pkg.sv
package shadd_pkg;
  typedef enum logic {
    MODE_SELECT = 1'b0,
    MODE_SHADD  = 1'b1
  } comb_mode_e;
endpackage

// File: rtl/shadd_ctrl_pipe.sv
module shadd_ctrl_pipe
  import shadd_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output comb_mode_e        mode_q_o,
  output logic              clr_q_o,
  output logic              capture_o
);
  logic [ADDR_W-1:0] addr_q, addr_d, prev_q, prev_d;
  comb_mode_e        mode_q, mode_d;
  logic              stg_vld_q, stg_vld_d;
  logic              prev_vld_q, prev_vld_d;
  logic              clr_q, clr_d;

  always_comb begin
    clr_d     = ~clr_n;
    addr_d    = addr_i;
    mode_d    = comb_mode_e'(mode_i);
    stg_vld_d = ~clr_q;
    if (clr_q) begin
      prev_d     = '0;
      prev_vld_d = 1'b0;
    end else begin
      prev_d     = addr_q;
      prev_vld_d = stg_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      mode_q     <= MODE_SELECT;
      stg_vld_q  <= 1'b0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      addr_q     <= addr_d;
      mode_q     <= mode_d;
      stg_vld_q  <= stg_vld_d;
      prev_q     <= prev_d;
      prev_vld_q <= prev_vld_d;
      clr_q      <= clr_d;
    end
  end

  assign capture_o = stg_vld_q & ~clr_q & (~prev_vld_q | (addr_q != prev_q));
  assign addr_q_o  = addr_q;
  assign mode_q_o  = mode_q;
  assign clr_q_o   = clr_q;
endmodule

// File: rtl/shadd_cell_mux.sv
module shadd_cell_mux #(
  parameter int N_CELLS = 8,
  parameter int ACC_W   = 26,
  localparam int ADDR_W = $clog2(N_CELLS)
) (
  input  logic [N_CELLS*ACC_W-1:0] cells_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [ACC_W-1:0]         sel_o
);
  logic [ACC_W-1:0] cell_arr [N_CELLS];

  for (genvar g = 0; g < N_CELLS; g++) begin : g_unpack
    assign cell_arr[g] = cells_i[g*ACC_W +: ACC_W];
  end

  always_comb begin
    sel_o = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      if (addr_i == ADDR_W'(i)) sel_o = cell_arr[i];
    end
  end
endmodule

// File: rtl/shadd_accum.sv
module shadd_accum
  import shadd_pkg::*;
#(
  parameter int ACC_W = 26,
  parameter int SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             capture_i,
  input  comb_mode_e       mode_i,
  input  logic             signed_i,
  input  logic [ACC_W-1:0] sel_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] res_o
);
  logic [ACC_W-1:0] acc_q, acc_d, res_q, res_d;
  logic [ACC_W-1:0] shifted, sum;
  logic             fill;

  assign fill    = signed_i & acc_q[ACC_W-1];
  assign shifted = {{SHIFT{fill}}, acc_q[ACC_W-1:SHIFT]};
  assign sum     = sel_i + shifted;

  always_comb begin
    acc_d = acc_q;
    res_d = res_q;
    if (clr_i) begin
      acc_d = '0;
      res_d = '0;
    end else if (capture_i) begin
      if (mode_i == MODE_SHADD) begin
        acc_d = sum;
        res_d = sum;
      end else begin
        res_d = sel_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      acc_q <= acc_d;
      res_q <= res_d;
    end
  end

  assign acc_o = acc_q;
  assign res_o = res_q;
endmodule

// File: rtl/shadd_half_gate.sv
module shadd_half_gate #(
  parameter int W = 16
) (
  input  logic [W-1:0] data_i,
  input  logic         en_n_i,
  output logic [W-1:0] data_o,
  output logic         vld_o
);
  assign vld_o  = ~en_n_i;
  assign data_o = en_n_i ? '0 : data_i;
endmodule

// File: rtl/shadd_combiner.sv
module shadd_combiner
  import shadd_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int ACC_W   = 26,
  parameter int SHIFT   = 8,
  parameter int LO_W    = 16,
  localparam int ADDR_W = $clog2(N_CELLS),
  localparam int HI_W   = ACC_W - LO_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_n,
  input  logic [N_CELLS*ACC_W-1:0] cell_acc_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     shadd_i,
  input  logic                     signed_i,
  input  logic                     en_lo_n,
  input  logic                     en_hi_n,
  output logic [LO_W-1:0]          out_lo_o,
  output logic                     out_lo_vld_o,
  output logic [HI_W-1:0]          out_hi_o,
  output logic                     out_hi_vld_o
);
  logic [ADDR_W-1:0] addr_q;
  comb_mode_e        mode_q;
  logic              clr_q, capture;
  logic [ACC_W-1:0]  sel, acc, res;

  shadd_ctrl_pipe #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .addr_i(addr_i), .mode_i(shadd_i),
    .addr_q_o(addr_q), .mode_q_o(mode_q), .clr_q_o(clr_q), .capture_o(capture)
  );

  shadd_cell_mux #(.N_CELLS(N_CELLS), .ACC_W(ACC_W)) mux_i (
    .cells_i(cell_acc_i), .addr_i(addr_q), .sel_o(sel)
  );

  shadd_accum #(.ACC_W(ACC_W), .SHIFT(SHIFT)) accum_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_q), .capture_i(capture), .mode_i(mode_q),
    .signed_i(signed_i), .sel_i(sel), .acc_o(acc), .res_o(res)
  );

  shadd_half_gate #(.W(LO_W)) lo_gate_i (
    .data_i(res[LO_W-1:0]), .en_n_i(en_lo_n), .data_o(out_lo_o), .vld_o(out_lo_vld_o)
  );

  shadd_half_gate #(.W(HI_W)) hi_gate_i (
    .data_i(res[ACC_W-1:LO_W]), .en_n_i(en_hi_n), .data_o(out_hi_o), .vld_o(out_hi_vld_o)
  );
endmodule

// File: rtl/shadd_combiner_chk.sv
module shadd_combiner_chk #(
  parameter int ACC_W = 26,
  parameter int LO_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_q,
  input logic             capture,
  input logic             mode_q,
  input logic [ACC_W-1:0] sel,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] res,
  input logic             en_lo_n,
  input logic             en_hi_n,
  input logic [LO_W-1:0]  out_lo,
  input logic             out_lo_vld,
  input logic [ACC_W-LO_W-1:0] out_hi,
  input logic             out_hi_vld
);
  a_r5_hold_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !clr_q) |=> $stable(res));

  a_r3_acc_frozen_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !clr_q) |=> $stable(acc));

  a_r2_select_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !mode_q && !clr_q) |=> (res == $past(sel)));

  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (res == '0 && acc == '0));

  a_r7_lo_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    en_lo_n |-> (out_lo == '0 && !out_lo_vld));

  a_r7_hi_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    en_hi_n |-> (out_hi == '0 && !out_hi_vld));

  a_r7_lo_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lo_n |-> (out_lo_vld && out_lo == res[LO_W-1:0]));
endmodule

bind shadd_combiner shadd_combiner_chk #(.ACC_W(ACC_W), .LO_W(LO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_q(clr_q), .capture(capture), .mode_q(mode_q),
  .sel(sel), .acc(acc), .res(res), .en_lo_n(en_lo_n), .en_hi_n(en_hi_n),
  .out_lo(out_lo_o), .out_lo_vld(out_lo_vld_o), .out_hi(out_hi_o), .out_hi_vld(out_hi_vld_o)
);

// File: tb/shadd_combiner_tb_top.sv
`timescale 1ns/1ps
module shadd_combiner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, clr_n, shadd, sgn, en_lo_n, en_hi_n;
  logic [2:0]  addr;
  logic [25:0] cells [8];
  logic [207:0] cells_flat;
  logic [15:0] out_lo;
  logic [9:0]  out_hi;
  logic        out_lo_vld, out_hi_vld;

  int checks = 0, failures = 0;
  string phase = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < 8; i++) cells_flat[i*26 +: 26] = cells[i];

  shadd_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cell_acc_i(cells_flat), .addr_i(addr),
    .shadd_i(shadd), .signed_i(sgn), .en_lo_n(en_lo_n), .en_hi_n(en_hi_n),
    .out_lo_o(out_lo), .out_lo_vld_o(out_lo_vld), .out_hi_o(out_hi), .out_hi_vld_o(out_hi_vld)
  );

  // behavioural reference model
  int          m_aq, m_ap;
  bit          m_mq, m_s1v, m_pv, m_clr;
  logic [25:0] m_acc, m_res, m_sel, m_shr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_aq = 0; m_ap = 0; m_mq = 0; m_s1v = 0; m_pv = 0; m_clr = 0;
      m_acc = 0; m_res = 0;
    end else begin
      if (m_clr) begin
        m_acc = 0; m_res = 0; m_ap = 0; m_pv = 0; m_s1v = 0;
      end else begin
        if (m_s1v && (!m_pv || m_aq != m_ap)) begin
          m_sel = cells[m_aq];
          if (m_mq) begin
            m_shr = m_acc / 256;
            if (sgn && m_acc[25]) m_shr = m_shr + 26'h3FC_0000;
            m_acc = m_sel + m_shr;
            m_res = m_acc;
          end else m_res = m_sel;
        end
        m_ap = m_aq; m_pv = m_s1v; m_s1v = 1;
      end
      m_aq = int'(addr); m_mq = shadd; m_clr = !clr_n;
    end
  end

  always @(posedge clk) begin
    #1;
    if (!done) begin
      checks++;
      if (out_lo !== (en_lo_n ? 16'h0 : m_res[15:0]) || out_lo_vld !== !en_lo_n) begin
        failures++;
        $display("FAIL %s lo: actual %h/%b expected %h/%b", phase, out_lo, out_lo_vld,
                 en_lo_n ? 16'h0 : m_res[15:0], !en_lo_n);
      end
      checks++;
      if (out_hi !== (en_hi_n ? 10'h0 : m_res[25:16]) || out_hi_vld !== !en_hi_n) begin
        failures++;
        $display("FAIL %s hi: actual %h/%b expected %h/%b", phase, out_hi, out_hi_vld,
                 en_hi_n ? 10'h0 : m_res[25:16], !en_hi_n);
      end
    end
  end

  task automatic step(input int a, input int n);
    for (int i = 0; i < n; i++) begin
      addr = 3'(a);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 0; clr_n = 1; shadd = 0; sgn = 0; en_lo_n = 0; en_hi_n = 0; addr = 0;
    for (int i = 0; i < 8; i++) cells[i] = 26'(32'h0123_4567 * (i + 1));
    // R1: reset state, outputs zero with both halves enabled
    repeat (3) @(negedge clk);
    checks++;
    if (out_lo !== 16'h0 || out_hi !== 10'h0) begin
      failures++;
      $display("FAIL R1 reset: actual %h %h expected 0 0", out_hi, out_lo);
    end
    rst_n = 1;
    @(negedge clk);
    // R2: select each cell in turn
    phase = "R2";
    for (int a = 0; a < 8; a++) step(a, 1);
    step(7, 2);
    // R5: hold address while addressed cell changes
    phase = "R5";
    step(3, 2);
    for (int i = 0; i < 4; i++) begin cells[3] = cells[3] + 26'h11111; step(3, 1); end
    // R6: address changes retrigger capture
    phase = "R6";
    step(2, 1); step(5, 1); step(2, 1); step(2, 2);
    // R3 / R9: shift-add across cells, unsigned
    phase = "R3";
    for (int i = 0; i < 8; i++) cells[i] = 26'h3F0_0000 + 26'(i * 32'h1357);
    shadd = 1;
    for (int a = 0; a < 8; a++) step(a, 1);
    phase = "R9";
    shadd = 0; step(6, 2);
    shadd = 1; step(1, 2);
    // R4: signed (arithmetic) shift with negative values
    phase = "R4";
    sgn = 1;
    for (int i = 0; i < 8; i++) cells[i] = 26'h3FF_F000 - 26'(i * 32'h321);
    for (int a = 7; a >= 0; a--) step(a, 1);
    step(4, 2);
    sgn = 0; step(0, 1); step(5, 2);
    // R7: enable combinations
    phase = "R7";
    shadd = 0;
    step(6, 2);
    en_lo_n = 1; step(6, 1);
    en_hi_n = 1; step(6, 1);
    en_lo_n = 0; step(6, 1);
    en_hi_n = 0; step(6, 1);
    // R8: synchronous clear, registered one clock
    phase = "R8";
    clr_n = 0; step(6, 1);
    clr_n = 1; step(6, 1); step(1, 3);
    shadd = 1; step(2, 1); step(3, 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule